// File: doc/BRIEF.md
# Static Latency-Insensitive Shell

This block wraps a small synchronous computation core so that it can sit on channels of any latency. Every input channel and the single output channel carry tokens with a valid flag going forward and a stop flag going back. A token whose valid flag is low is a void token. The core computes one step only when a valid token stands at the head of every input and the output side is not stopping. In that cycle one token is taken from each input, and the core's new result goes out as a valid token on the next clock edge.

In any other cycle the core's clock enable is held off, so its internal state keeps its value. The output then carries a void token, or keeps its last valid token in place while the output is stopped. Each input has a two-slot buffer that holds tokens arriving ahead of the others. A buffer that is full raises stop toward its producer.

A token that reaches an empty buffer in a cycle where the core fires passes straight through, so the shell adds a single register stage to a path. The core here is a stand-in: a running sum of all input tokens, modulo 2^W. The k-th valid output is therefore the previous output plus the k-th token of every input. That makes the alignment of tokens across channels directly visible.

Top module: `li_shell`

## Requirements
- R1: While rst_n is sampled low, and in the first cycle after it, out_valid is 0 and every bit of in_stop is 0 (all buffers empty).
- R2: The core fires in a cycle exactly when every input has a token available (buffered, or presented with in_valid high and in_stop low) and out_stop is low. A firing cycle makes out_valid 1 after the next rising edge.
- R3: The k-th valid token accepted from the output (out_valid high, out_stop low) equals, modulo 2^W, the previous accepted output value (0 after reset) plus the k-th accepted token of every input. Input i occupies in_data bits [i*W +: W].
- R4: In a cycle where some input has no token and out_stop is low, the next output token is void (out_valid 0), and no token is taken from any input.
- R5: While out_valid is 1 and out_stop is 1, out_valid and out_data keep their values on the next edge.
- R6: in_stop[i] is 1 exactly when input i's buffer holds two tokens. A token presented while in_stop[i] is 1 is not taken, and the producer must keep presenting it.
- R7: A token arriving at an empty buffer in a cycle where the core fires is used in that same cycle, so out_valid rises one edge after in_valid.
- R8: In a ring made of one single-input shell and two plain register stages holding one token in total, exactly one output token in three is valid once the ring runs.
- R9: No input token is lost or duplicated. Once inputs go idle and out_stop stays low, every complete set of one token per input has produced its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N_IN | Per input: token valid |
| in_data | input | N_IN*W | Input tokens, input i at bits [i*W +: W] |
| in_stop | output | N_IN | Per input: buffer full, producer must hold its token |
| out_valid | output | 1 | Output token valid |
| out_data | output | W | Output token value |
| out_stop | input | 1 | Consumer stops the output token |

## Verification
The bench goes after four cases.

- **Inputs that arrive at different times.** A wrapper that fired on a partial set of tokens, or popped only some buffers, would mix labels across channels. The running sum would then drift from the model.
- **A full buffer facing a long output stop.** Mishandled back-pressure would drop or duplicate the third token; a late in_stop would let a token be overwritten.
- **Output stop with a valid token pending.** A design that voided or replaced the output here would lose a result.
- **The three-stage ring.** Any extra latency in the pass-through path would show as a rate of one in four instead of one in three.

// File: rtl/li_shell_pkg.sv
// Shared types of the latency-insensitive shell.
// Assumes: nothing beyond the standard language.
package li_shell_pkg;

    // Fill level of a two-slot input buffer.
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_FULL  = 2'd2
    } fill_e;

    // What the output stage does on the coming edge.
    typedef enum logic [1:0] {
        STEP_VOID = 2'd0,
        STEP_FIRE = 2'd1,
        STEP_HOLD = 2'd2
    } step_e;

endpackage

// File: rtl/li_in_queue.sv
// Two-slot input buffer for one channel.
// Takes a token when in_valid is high and in_stop is low. When it is empty
// and the shell fires in the same cycle, the token bypasses the storage.
// Pops one stored token on every firing cycle.
// Assumes: fire is only raised when head_valid is high.
module li_in_queue
    import li_shell_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_valid,
    input  logic [W-1:0] up_data,
    output logic         up_stop,
    input  logic         fire,
    output logic         head_valid,
    output logic [W-1:0] head_data
);
    logic [W-1:0] slot [2];
    logic         rd_idx;
    fill_e        fill;

    logic take, bypass, push, pop;
    logic wr_idx;

    // Handshake and head selection.
    always_comb begin
        up_stop    = (fill == FILL_FULL);
        take       = up_valid && !up_stop;
        bypass     = take && (fill == FILL_EMPTY) && fire;
        push       = take && !bypass;
        pop        = fire && (fill != FILL_EMPTY);
        head_valid = (fill != FILL_EMPTY) || take;
        head_data  = (fill != FILL_EMPTY) ? slot[rd_idx] : up_data;
        wr_idx     = (fill == FILL_ONE) ? !rd_idx : rd_idx;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            slot[wr_idx] <= up_data;
        end
    end

    // Read pointer and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= 1'b0;
            fill   <= FILL_EMPTY;
        end else begin
            if (pop) begin
                rd_idx <= !rd_idx;
            end
            case ({push, pop})
                2'b10:   fill <= (fill == FILL_EMPTY) ? FILL_ONE : FILL_FULL;
                2'b01:   fill <= (fill == FILL_FULL) ? FILL_ONE : FILL_EMPTY;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/li_fire_ctrl.sv
// Firing decision of the shell.
// Fires when every input head is valid and the output is not stopped.
// Otherwise it holds a stopped valid output, or emits a void token.
// Assumes: head_valid bits are settled within the cycle.
module li_fire_ctrl
    import li_shell_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic [N_IN-1:0] head_valid,
    input  logic            out_stop,
    input  logic            out_valid,
    output logic            fire,
    output step_e           step
);
    // Decide the step for the coming edge.
    always_comb begin
        fire = (&head_valid) && !out_stop;
        if (fire) begin
            step = STEP_FIRE;
        end else if (out_stop && out_valid) begin
            step = STEP_HOLD;
        end else begin
            step = STEP_VOID;
        end
    end

endmodule

// File: rtl/li_pearl.sv
// Stand-in computation core with its output register.
// State advances only on STEP_FIRE (the clock enable): the accumulator adds
// the head token of every input, and the new total is sent out as valid.
// Assumes: step is STEP_FIRE only when all heads hold valid tokens.
module li_pearl
    import li_shell_pkg::*;
#(
    parameter int N_IN = 2,
    parameter int W    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  step_e           step,
    input  logic [N_IN*W-1:0] heads,
    output logic            out_valid,
    output logic [W-1:0]    out_data
);
    logic [W-1:0] acc;
    logic [W-1:0] total;

    // Sum of the accumulator and all head tokens.
    always_comb begin
        total = acc;
        for (int i = 0; i < N_IN; i++) begin
            total = total + heads[i*W +: W];
        end
    end

    // Core state, gated by the firing step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (step == STEP_FIRE) begin
            acc <= total;
        end
    end

    // Output token register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            case (step)
                STEP_FIRE: begin
                    out_valid <= 1'b1;
                    out_data  <= total;
                end
                STEP_HOLD: begin
                    out_valid <= out_valid;
                    out_data  <= out_data;
                end
                default: begin
                    out_valid <= 1'b0;
                    out_data  <= out_data;
                end
            endcase
        end
    end

endmodule

// File: rtl/li_shell.sv
// Static latency-insensitive shell around the stand-in core.
// One two-slot buffer per input, a firing controller and the gated core.
// Assumes: producers hold a token while its stop bit is high; the
// consumer holds the output while it drives out_stop.
module li_shell
    import li_shell_pkg::*;
#(
    parameter int N_IN = 2,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   in_valid,
    input  logic [N_IN*W-1:0] in_data,
    output logic [N_IN-1:0]   in_stop,
    output logic              out_valid,
    output logic [W-1:0]      out_data,
    input  logic              out_stop
);
    logic [N_IN-1:0]   head_valid;
    logic [N_IN*W-1:0] heads;
    logic              fire;
    step_e             step;

    // One buffer per input channel.
    for (genvar g = 0; g < N_IN; g++) begin : g_in
        li_in_queue #(.W(W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .up_valid  (in_valid[g]),
            .up_data   (in_data[g*W +: W]),
            .up_stop   (in_stop[g]),
            .fire      (fire),
            .head_valid(head_valid[g]),
            .head_data (heads[g*W +: W])
        );
    end

    li_fire_ctrl #(.N_IN(N_IN)) u_ctrl (
        .head_valid(head_valid),
        .out_stop  (out_stop),
        .out_valid (out_valid),
        .fire      (fire),
        .step      (step)
    );

    li_pearl #(.N_IN(N_IN), .W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .heads    (heads),
        .out_valid(out_valid),
        .out_data (out_data)
    );

endmodule

// File: rtl/li_shell_checker.sv
// Protocol checks for the shell, bound into every li_shell instance.
module li_shell_checker #(
    parameter int N_IN = 2,
    parameter int W    = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] in_stop,
    input logic [N_IN-1:0] head_valid,
    input logic            fire,
    input logic            out_valid,
    input logic [W-1:0]    out_data,
    input logic            out_stop
);
    // R1: reset empties the buffers and voids the output.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_stop == '0));

    // R2: a firing cycle yields a valid token.
    a_r2_fire_valid: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> out_valid);

    // R4: a missing input with no stop gives a void token.
    a_r4_void_on_missing: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&head_valid) && !out_stop) |=> !out_valid);

    // R5: a stopped valid token stays in place.
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_stop) |=> (out_valid && $stable(out_data)));

    // R6: a full buffer stays full until the core fires.
    for (genvar g = 0; g < N_IN; g++) begin : g_chk
        a_r6_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (in_stop[g] && !fire) |=> in_stop[g]);
        a_r6_stop_has_head: assert property (@(posedge clk) disable iff (!rst_n)
            in_stop[g] |-> head_valid[g]);
    end

endmodule

bind li_shell li_shell_checker #(.N_IN(N_IN), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stop   (in_stop),
    .head_valid(head_valid),
    .fire      (fire),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_stop  (out_stop)
);

// File: tb/li_shell_test.sv
`timescale 1ns/1ps
// Bench for li_shell: directed corners, seeded random traffic, and a ring.
module li_shell_test;
    localparam int N = 3;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   in_valid = '0;
    logic [N*W-1:0] in_data  = '0;
    logic [N-1:0]   in_stop;
    logic           out_valid;
    logic [W-1:0]   out_data;
    logic           out_stop = 1'b0;

    li_shell #(.N_IN(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_stop(in_stop), .out_valid(out_valid), .out_data(out_data),
        .out_stop(out_stop)
    );

    // Ring: one single-input shell and two register stages, one token.
    logic         r_valid, r_stop;
    logic [W-1:0] r_data;
    logic         rs1_v, rs2_v;
    logic [W-1:0] rs1_d, rs2_d;

    li_shell #(.N_IN(1), .W(W)) u_ring (
        .clk(clk), .rst_n(rst_n), .in_valid(rs2_v), .in_data(rs2_d),
        .in_stop(r_stop), .out_valid(r_valid), .out_data(r_data),
        .out_stop(1'b0)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs1_v <= 1'b0; rs1_d <= '0;
            rs2_v <= 1'b1; rs2_d <= 8'd1;
        end else begin
            rs1_v <= r_valid; rs1_d <= r_data;
            rs2_v <= rs1_v;   rs2_d <= rs1_d;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0] q0[$], q1[$], q2[$];
    logic [W-1:0] run_sum = '0;
    bit           busy [N];
    bit           was_hold = 1'b0;
    logic [W-1:0] hold_data = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model_next(input logic [W-1:0] base,
        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        return base + a + b + c;
    endfunction

    // One cycle: drive at the falling edge, then do the bookkeeping.
    task automatic tick(input logic [N-1:0] v, input logic [N*W-1:0] d, input logic st);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (!busy[i]) begin
                in_valid[i] = v[i];
                in_data[i*W +: W] = d[i*W +: W];
            end
        end
        out_stop = st;
        #1;
        // R5: a token stopped last cycle must still be there.
        if (was_hold) begin
            check(out_valid && out_data == hold_data, "R5",
                  int'(out_data), int'(hold_data));
        end
        was_hold = out_valid && out_stop;
        hold_data = out_data;
        // R3: accepted output against the running-sum model.
        if (out_valid && !out_stop) begin
            if (q0.size() == 0 || q1.size() == 0 || q2.size() == 0) begin
                check(1'b0, "R9", int'(out_data), -1);
            end else begin
                run_sum = model_next(run_sum, q0.pop_front(), q1.pop_front(), q2.pop_front());
                check(out_data == run_sum, "R3", int'(out_data), int'(run_sum));
            end
        end
        // R6: record tokens the shell takes at the coming edge.
        for (int i = 0; i < N; i++) begin
            if (in_valid[i] && !in_stop[i]) begin
                case (i)
                    0: q0.push_back(in_data[0 +: W]);
                    1: q1.push_back(in_data[W +: W]);
                    default: q2.push_back(in_data[2*W +: W]);
                endcase
                busy[i] = 1'b0;
            end else begin
                busy[i] = in_valid[i];
            end
        end
    endtask

    // Main sequence.
    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) busy[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", int'(out_valid), 0);
        check(in_stop == '0, "R1", int'(in_stop), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: all inputs arrive together into empty buffers.
        tick(3'b111, {8'd3, 8'd2, 8'd1}, 1'b0);
        @(posedge clk); #1;
        check(out_valid == 1'b1, "R7", int'(out_valid), 1);
        check(out_data == 8'd6, "R7", int'(out_data), 6);

        // R4: input 2 missing, output must go void.
        tick(3'b011, {8'd0, 8'd20, 8'd10}, 1'b0);
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R4", int'(out_valid), 0);
        tick(3'b100, {8'd30, 8'd0, 8'd0}, 1'b0);
        @(posedge clk); #1;
        check(out_valid == 1'b1 && out_data == 8'd66, "R2", int'(out_data), 66);

        // R6/R5: long output stop, input 0 streams tokens.
        for (int k = 0; k < 4; k++) tick(3'b001, {8'd0, 8'd0, 8'(40 + k)}, 1'b1);
        @(posedge clk); #1;
        check(in_stop == 3'b001, "R6", int'(in_stop), 1);
        check(busy[0] == 1'b1, "R6", int'(busy[0]), 1);
        // Release and complete the sets.
        for (int k = 0; k < 4; k++) tick(3'b110, {8'(7 * k), 8'(5 * k), 8'd0}, 1'b0);
        for (int k = 0; k < 4; k++) tick(3'b000, '0, 1'b0);

        // Seeded random traffic with random output stops.
        for (int k = 0; k < 3000; k++) begin
            tick(N'($urandom), (N*W)'({$urandom, $urandom}), ($urandom % 4) == 0);
        end

        // R9: drain; every complete set must have produced its output.
        for (int k = 0; k < 12; k++) tick(3'b000, '0, 1'b0);
        check((q0.size() == 0) || (q1.size() == 0) || (q2.size() == 0), "R9",
              q0.size() + q1.size() + q2.size(), 0);
        check(out_valid == 1'b0, "R9", int'(out_valid), 0);

        // R8: ring rate, one valid token in three.
        begin
            int seen = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (r_valid) seen++;
            end
            check(seen == 100, "R8", seen, 100);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule